// File: doc/BRIEF.md
# Epoch-Based Way-Partition Optimizer

This block decides how the ways of a set-associative cache are split between ordinary data lines and address-translation lines. The cache reports every hit, tagged with the class of the line (data or translation) and that line's recency rank inside its own region, where rank 0 is the most recently used. The block keeps one array of hit counters per class, with one counter per recency rank. Each array shows how many hits its region would keep if the region were shrunk to a given number of ways.

When the epoch-end pulse arrives, the block freezes the counts and scans every candidate boundary N, one per cycle. A candidate N gives the data region ways 0..N-1 and the translation region the remaining ways. Its score is the weighted sum of the data hits in ranks below N plus the weighted sum of the translation hits in ranks 0..W-N-1. The two weights are unsigned fixed-point gain factors supplied from outside. Both weights share the same scaling, so no shift is applied. The best candidate becomes the new boundary, and a one-cycle done strobe marks the update.

Top module: `way_part_opt`

## Requirements
- R1: After reset, the boundary output equals W/2 (4 for the default W=8) and the done strobe is low.
- R2: A hit increments only the counter of its own class (hit_xlat_i=0 for data, 1 for translation) at the rank given by hit_pos_i.
- R3: Candidate N scores wgt_data_i × (data counts at ranks 0..N-1) + wgt_xlat_i × (translation counts at ranks 0..W-N-1). The highest-scoring N in 0..W-1 is chosen. Weights are sampled in the cycle the epoch ends.
- R4: Among equal scores, the candidate nearest the current boundary wins. If two candidates are equally near, the smaller N wins. With no hits at all, the boundary therefore stays where it is.
- R5: The done strobe is high for exactly one cycle, W cycles after the clock edge that accepts epoch_end_i. The boundary changes only in that cycle.
- R6: Counters clear when an epoch end is accepted. A hit in that same cycle, or during the scan, is counted in the new epoch.
- R7: Counters saturate at 2^CNT_W-1 instead of wrapping.
- R8: An epoch_end_i pulse that arrives while a scan is running is ignored. It neither clears the counters nor restarts the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld_i | input | 1 | A cache hit occurs this cycle |
| hit_xlat_i | input | 1 | Class of the hit line: 0 data, 1 translation |
| hit_pos_i | input | $clog2(WAYS) | Recency rank of the hit line in its region (0 = most recent) |
| epoch_end_i | input | 1 | Closes the current epoch and starts a scan |
| wgt_data_i | input | WGT_W | Gain factor for data hits |
| wgt_xlat_i | input | WGT_W | Gain factor for translation hits |
| part_n_o | output | $clog2(WAYS) | Current boundary N (ways given to data) |
| done_o | output | 1 | One-cycle strobe when a new N is written |

## Verification
A wrong counter, running sum or weight stays hidden until the next scan. It then shows up as a different boundary on part_n_o in the done cycle, W cycles after the epoch end. Each epoch is therefore set up so that a wrong count, a lost saturation or a swapped weight moves the chosen N. A fault in the scan sequencing shows up sooner: done_o arrives at the wrong edge, or part_n_o moves outside the done cycle, and the bound checker flags either case at the next edge.

// File: rtl/wpo_pkg.sv
package wpo_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;
endpackage

// File: rtl/wpo_hit_bank.sv
// One region's recency-rank hit counters, saturating, cleared on epoch close.
module wpo_hit_bank #(
    parameter int WAYS  = 8,
    parameter int CNT_W = 12,
    localparam int PW   = $clog2(WAYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          inc_i,
    input  logic [PW-1:0]                 pos_i,
    output logic [WAYS-1:0][CNT_W-1:0]    cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WAYS-1:0][CNT_W-1:0] cnt;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < WAYS; i++) begin
            if (clr_i) s_d.cnt[i] = '0;
            if (inc_i && (pos_i == PW'(i)) && (s_d.cnt[i] != CNT_MAX))
                s_d.cnt[i] = s_d.cnt[i] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/wpo_scan.sv
// Serial candidate scan: one boundary per cycle with running prefix sums.
module wpo_scan
    import wpo_pkg::*;
#(
    parameter int WAYS    = 8,
    parameter int CNT_W   = 12,
    parameter int WGT_W   = 8,
    localparam int PW      = $clog2(WAYS),
    localparam int SUM_W   = CNT_W + PW + 1,
    localparam int SCORE_W = SUM_W + WGT_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [WAYS-1:0][CNT_W-1:0]    cnt_d_i,
    input  logic [WAYS-1:0][CNT_W-1:0]    cnt_t_i,
    input  logic [WGT_W-1:0]              wgt_d_i,
    input  logic [WGT_W-1:0]              wgt_t_i,
    output logic                          busy_o,
    output logic [PW-1:0]                 part_n_o,
    output logic                          done_o
);
    typedef struct packed {
        phase_e                      phase;
        logic [PW-1:0]               idx;
        logic [WAYS-1:0][CNT_W-1:0]  snap_d;
        logic [WAYS-1:0][CNT_W-1:0]  snap_t;
        logic [SUM_W-1:0]            sum_d;
        logic [SUM_W-1:0]            sum_t;
        logic [WGT_W-1:0]            wd;
        logic [WGT_W-1:0]            wt;
        logic [PW-1:0]               best_n;
        logic [SCORE_W-1:0]          best_s;
        logic [PW-1:0]               part_n;
        logic                        done;
    } scan_t;

    localparam logic [PW-1:0] LAST_IDX = PW'(WAYS - 1);
    localparam logic [PW-1:0] HALF_N   = PW'(WAYS / 2);

    scan_t s_d, s_q;

    logic [SUM_W-1:0]   total_t;
    logic [SCORE_W-1:0] score;
    logic [PW-1:0]      dist_k;
    logic [PW-1:0]      dist_b;
    logic               better;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;

        total_t = '0;
        for (int i = 0; i < WAYS; i++)
            total_t = total_t + SUM_W'(cnt_t_i[i]);

        score  = SCORE_W'(s_q.wd) * SCORE_W'(s_q.sum_d)
               + SCORE_W'(s_q.wt) * SCORE_W'(s_q.sum_t);
        dist_k = (s_q.idx > s_q.part_n) ? (s_q.idx - s_q.part_n)
                                        : (s_q.part_n - s_q.idx);
        dist_b = (s_q.best_n > s_q.part_n) ? (s_q.best_n - s_q.part_n)
                                           : (s_q.part_n - s_q.best_n);
        better = (score > s_q.best_s)
              || ((score == s_q.best_s)
                  && ((dist_k < dist_b)
                      || ((dist_k == dist_b) && (s_q.idx < s_q.best_n))));

        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase  = PH_SCAN;
                    s_d.idx    = '0;
                    s_d.snap_d = cnt_d_i;
                    s_d.snap_t = cnt_t_i;
                    s_d.sum_d  = '0;
                    s_d.sum_t  = total_t;
                    s_d.wd     = wgt_d_i;
                    s_d.wt     = wgt_t_i;
                    s_d.best_n = s_q.part_n;
                    s_d.best_s = '0;
                end
            end
            default: begin
                if (better) begin
                    s_d.best_n = s_q.idx;
                    s_d.best_s = score;
                end
                s_d.sum_d = s_q.sum_d + SUM_W'(s_q.snap_d[s_q.idx]);
                s_d.sum_t = s_q.sum_t - SUM_W'(s_q.snap_t[LAST_IDX - s_q.idx]);
                s_d.idx   = s_q.idx + 1'b1;
                if (s_q.idx == LAST_IDX) begin
                    s_d.phase  = PH_IDLE;
                    s_d.part_n = better ? s_q.idx : s_q.best_n;
                    s_d.done   = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.phase  <= PH_IDLE;
            s_q.part_n <= HALF_N;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = (s_q.phase == PH_SCAN);
    assign part_n_o = s_q.part_n;
    assign done_o   = s_q.done;
endmodule

// File: rtl/way_part_opt.sv
module way_part_opt #(
    parameter int WAYS  = 8,
    parameter int CNT_W = 12,
    parameter int WGT_W = 8,
    localparam int PW   = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_vld_i,
    input  logic              hit_xlat_i,
    input  logic [PW-1:0]     hit_pos_i,
    input  logic              epoch_end_i,
    input  logic [WGT_W-1:0]  wgt_data_i,
    input  logic [WGT_W-1:0]  wgt_xlat_i,
    output logic [PW-1:0]     part_n_o,
    output logic              done_o
);
    logic                       busy;
    logic                       start;
    logic [WAYS-1:0][CNT_W-1:0] cnt_data;
    logic [WAYS-1:0][CNT_W-1:0] cnt_xlat;

    // an epoch close is only taken while no scan is running
    assign start = epoch_end_i && !busy;

    wpo_hit_bank #(.WAYS(WAYS), .CNT_W(CNT_W)) u_bank_data (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start),
        .inc_i (hit_vld_i && !hit_xlat_i),
        .pos_i (hit_pos_i),
        .cnt_o (cnt_data)
    );

    wpo_hit_bank #(.WAYS(WAYS), .CNT_W(CNT_W)) u_bank_xlat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start),
        .inc_i (hit_vld_i && hit_xlat_i),
        .pos_i (hit_pos_i),
        .cnt_o (cnt_xlat)
    );

    wpo_scan #(.WAYS(WAYS), .CNT_W(CNT_W), .WGT_W(WGT_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .cnt_d_i  (cnt_data),
        .cnt_t_i  (cnt_xlat),
        .wgt_d_i  (wgt_data_i),
        .wgt_t_i  (wgt_xlat_i),
        .busy_o   (busy),
        .part_n_o (part_n_o),
        .done_o   (done_o)
    );
endmodule

// File: rtl/wpo_checker.sv
module wpo_checker #(
    parameter int WAYS = 8,
    localparam int PW  = $clog2(WAYS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          epoch_end_i,
    input logic [PW-1:0] part_n_o,
    input logic          done_o
);
    // independent scan tracker seen from the ports only
    logic          trk_busy_q;
    logic [PW-1:0] trk_cnt_q;
    logic          trk_last;

    assign trk_last = trk_busy_q && (trk_cnt_q == PW'(WAYS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_busy_q <= 1'b0;
            trk_cnt_q  <= '0;
        end else if (!trk_busy_q) begin
            if (epoch_end_i) begin
                trk_busy_q <= 1'b1;
                trk_cnt_q  <= '0;
            end
        end else if (trk_last) begin
            trk_busy_q <= 1'b0;
        end else begin
            trk_cnt_q <= trk_cnt_q + 1'b1;
        end
    end

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (part_n_o == PW'(WAYS / 2)) && !done_o);

    assert_done_on_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trk_last |=> done_o);

    assert_no_stray_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_last |=> !done_o);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(part_n_o));
endmodule

bind way_part_opt wpo_checker #(.WAYS(WAYS)) u_wpo_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .epoch_end_i (epoch_end_i),
    .part_n_o    (part_n_o),
    .done_o      (done_o)
);

// File: tb/sim_way_part_opt.sv
`timescale 1ns/1ps
module sim_way_part_opt;
    localparam int WAYS  = 8;
    localparam int CNT_W = 12;
    localparam int WGT_W = 8;
    localparam int PW    = $clog2(WAYS);
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hit_vld = 1'b0;
    logic             hit_xlat = 1'b0;
    logic [PW-1:0]    hit_pos = '0;
    logic             epoch_end = 1'b0;
    logic [WGT_W-1:0] wgt_data = '0;
    logic [WGT_W-1:0] wgt_xlat = '0;
    logic [PW-1:0]    part_n;
    logic             done;

    int checks = 0;
    int fails  = 0;
    int md[WAYS];
    int mt[WAYS];
    int exp_n = WAYS / 2;

    way_part_opt #(.WAYS(WAYS), .CNT_W(CNT_W), .WGT_W(WGT_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_vld_i   (hit_vld),
        .hit_xlat_i  (hit_xlat),
        .hit_pos_i   (hit_pos),
        .epoch_end_i (epoch_end),
        .wgt_data_i  (wgt_data),
        .wgt_xlat_i  (wgt_xlat),
        .part_n_o    (part_n),
        .done_o      (done)
    );

    always #2.5 clk = ~clk;

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // reference choice: best score, then nearest to cur, then smaller N
    function automatic int pick_n(int wd, int wt, int cur);
        longint best_s = -1;
        int     best   = 0;
        for (int n = 0; n < WAYS; n++) begin
            longint sd = 0;
            longint st = 0;
            longint s;
            int d;
            int bd;
            for (int i = 0; i < n; i++) sd += md[i];
            for (int i = 0; i <= WAYS - n - 1; i++) st += mt[i];
            s  = longint'(wd) * sd + longint'(wt) * st;
            d  = (n > cur) ? n - cur : cur - n;
            bd = (best > cur) ? best - cur : cur - best;
            if (s > best_s || (s == best_s && d < bd)) begin
                best_s = s;
                best   = n;
            end
        end
        return best;
    endfunction

    task automatic add_hit(bit x, int p);
        if (x) begin if (mt[p] < CMAX) mt[p]++; end
        else   begin if (md[p] < CMAX) md[p]++; end
    endtask

    task automatic drive(bit v, bit x, int p, bit e);
        @(negedge clk);
        hit_vld   = v;
        hit_xlat  = x;
        hit_pos   = PW'(p);
        epoch_end = e;
    endtask

    task automatic hit(bit x, int p);
        drive(1'b1, x, p, 1'b0);
        add_hit(x, p);
    endtask

    task automatic clear_model();
        for (int i = 0; i < WAYS; i++) begin md[i] = 0; mt[i] = 0; end
    endtask

    task automatic run_epoch(int wd, int wt, bit traffic, string tag);
        int e;
        e = pick_n(wd, wt, exp_n);
        clear_model();
        wgt_data = WGT_W'(wd);
        wgt_xlat = WGT_W'(wt);
        if (traffic) begin
            bit x = 1'($urandom_range(0, 1));
            int p = $urandom_range(0, WAYS - 1);
            drive(1'b1, x, p, 1'b1);   // R6: hit in the closing cycle goes to the new epoch
            add_hit(x, p);
        end else begin
            drive(1'b0, 1'b0, 0, 1'b1);
        end
        for (int k = 1; k < WAYS; k++) begin
            if (traffic && k == 2) begin
                drive(1'b0, 1'b0, 0, 1'b1);   // R8: ignored mid-scan close
            end else if (traffic) begin
                bit x = 1'($urandom_range(0, 1));
                int p = $urandom_range(0, WAYS - 1);
                drive(1'b1, x, p, 1'b0);
                add_hit(x, p);
            end else begin
                drive(1'b0, 1'b0, 0, 1'b0);
            end
        end
        @(negedge clk);
        check("R5 done early", int'(done), 0);
        check("R5 N moved early", int'(part_n), exp_n);
        hit_vld = 1'b0; epoch_end = 1'b0;
        @(negedge clk);
        check("R5 done strobe", int'(done), 1);
        check(tag, int'(part_n), e);
        @(negedge clk);
        check("R5 done width", int'(done), 0);
        exp_n = e;
    endtask

    initial begin
        #750000.0;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_model();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset N", int'(part_n), WAYS / 2);
        check("R1 reset done", int'(done), 0);

        // R4: no hits at all keeps the boundary
        run_epoch(16, 16, 1'b0, "R4 empty epoch keeps N");

        // R4: equal-distance tie between 3 and 5 resolves to 3
        for (int i = 0; i < 5;  i++) hit(1'b1, 4);
        for (int i = 0; i < 10; i++) hit(1'b0, 4);
        for (int i = 0; i < 5;  i++) hit(1'b1, 3);
        run_epoch(16, 16, 1'b0, "R4 tie smaller N");
        check("R4 tie value", int'(part_n), 3);

        // R2/R3: weights steer the choice toward one region
        for (int i = 0; i < 10; i++) hit(1'b0, 5);
        for (int i = 0; i < 10; i++) hit(1'b1, 5);
        run_epoch(32, 16, 1'b0, "R3 data weight");
        check("R3 data weight value", int'(part_n), 6);
        for (int i = 0; i < 10; i++) hit(1'b0, 5);
        for (int i = 0; i < 10; i++) hit(1'b1, 5);
        run_epoch(16, 32, 1'b0, "R3 xlat weight");
        check("R3 xlat weight value", int'(part_n), 2);

        // R2: class routing at a single rank
        for (int i = 0; i < 7; i++) hit(1'b1, 6);
        run_epoch(16, 16, 1'b0, "R2 class routing");

        // R6/R8: hits during the scan and a mid-scan close
        for (int i = 0; i < 40; i++) hit(1'($urandom_range(0, 1)), $urandom_range(0, WAYS - 1));
        run_epoch(20, 40, 1'b1, "R6 epoch with scan traffic");
        run_epoch(40, 20, 1'b0, "R8 counts kept past ignored close");

        // R7: saturation decides the result
        for (int i = 0; i < 5000; i++) hit(1'b0, 0);
        for (int i = 0; i < 3000; i++) hit(1'b1, 7);
        run_epoch(16, 16, 1'b0, "R7 saturation");
        check("R7 saturation not wrap", (part_n == 0) ? 1 : 0, 0);

        // random epochs
        for (int ep = 0; ep < 20; ep++) begin
            int len = $urandom_range(50, 300);
            for (int c = 0; c < len; c++) begin
                if ($urandom_range(0, 3) != 0)
                    hit(1'($urandom_range(0, 1)), $urandom_range(0, WAYS - 1));
                else
                    drive(1'b0, 1'b0, 0, 1'b0);
            end
            run_epoch($urandom_range(1, 255), $urandom_range(1, 255),
                      1'(ep % 3 == 0), "R3 random epoch");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule